// File: doc/BRIEF.md
# Keyed Low-Power Mode Controller

This block sequences a small microcontroller between its running state and two power-saving states. Software programs two byte-wide registers over a simple register bus. The first register holds an idle request flag and a power-down request flag. The second holds an eight-bit key. A low-power state is entered only when a request flag is set and the key register holds the unlock byte. A single stray write to either register therefore cannot stop the processor.

In idle, only the CPU clock enable drops. The peripheral clock enable stays high, so interrupts, ports, timers, the watchdog and the USB engine keep running. An enabled interrupt returns the block to run. In power-down, the oscillator enable drops and every clock halts. An asynchronous wake input restores the oscillator enable at once. After the wake has crossed a synchronizer and a settle interval has elapsed, the block sends a one-cycle resume pulse to other blocks and returns to run.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `mode` is 00, `resume` is 0, and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1.
- R2: Address 0 is the power control register. Bit 0 is the idle request and bit 1 is the power-down request. Bits 7:2 ignore writes and read as 0.
- R3: Address 1 is the key register. All eight bits are writable and read back as written. The unlock value is 0x55.
- R4: In run, an idle request with the key at 0x55 and no power-down request moves the block to idle on the next clock edge. Idle reports `mode`=01, with `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R5: In run, a power-down request with the key at 0x55 moves the block to power-down on the next clock edge. Power-down reports `mode`=10, with `cpu_clk_en`, `per_clk_en` and `osc_en` all 0 while `wake_async` is low.
- R6: While the key register is not 0x55, no combination of request bits leaves run.
- R7: When both request bits are set and the key is 0x55, power-down wins over idle.
- R8: `irq_wake` high in idle returns the block to run on the next edge. The same edge clears the idle request bit and the key register.
- R9: `irq_wake` has no effect in run or in power-down.
- R10: In power-down, `osc_en` follows a high `wake_async` without any clock. After a two-flop synchronizer, `SETTLE_CYC` further cycles pass in `mode` 10. Then `resume` pulses for exactly one cycle, and on the next edge the block is in run with both registers at 0x00.
- R11: Register writes are ignored in idle and power-down.
- R12: `mode` never shows the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 power control, 1 key |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_wake | input | 1 | Enabled pending interrupt, exits idle |
| wake_async | input | 1 | Asynchronous wake request, exits power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 00 run, 01 idle, 10 power-down |
| resume | output | 1 | One-cycle pulse after power-down exit |

## Verification
The entry condition is tried with directed patterns. The key alone, request bits alone, a near-miss key of 0x54 and both request bits set tell a true unlock from a missing key and show which mode has priority. Random writes to both registers, with the unlock byte favoured, then walk many orders of key and request writes. Each step is compared with a model of when entry must happen. Every idle entry is left by an interrupt and every power-down by the wake input, so the exit path, the clearing of the registers and the exact cycle of the resume pulse are checked many times. Writes made while asleep and interrupts seen in run or power-down are each checked at the ports and must change nothing.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_DOWN = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_IDLE,
    ST_DOWN,
    ST_WARM
  } state_e;

  localparam logic [7:0] UNLOCK_KEY    = 8'h55;
  localparam logic       ADDR_CTRL     = 1'b0;
  localparam logic       ADDR_KEY      = 1'b1;
  localparam int         CTRL_IDLE_BIT = 0;
  localparam int         CTRL_DOWN_BIT = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       clr_idle,
  input  logic       clr_all,
  output logic       idle_req,
  output logic       down_req,
  output logic       key_ok,
  output logic [7:0] rdata
);
  logic       idle_q, idle_d;
  logic       down_q, down_d;
  logic [7:0] key_q, key_d;
  logic       upd_en;

  assign upd_en = wr_en | clr_idle | clr_all;

  always_comb begin
    idle_d = idle_q;
    down_d = down_q;
    key_d  = key_q;
    if (wr_en && addr == ADDR_CTRL) begin
      idle_d = wdata[CTRL_IDLE_BIT];
      down_d = wdata[CTRL_DOWN_BIT];
    end
    if (wr_en && addr == ADDR_KEY) key_d = wdata;
    if (clr_idle) begin
      idle_d = 1'b0;
      key_d  = 8'h00;
    end
    if (clr_all) begin
      idle_d = 1'b0;
      down_d = 1'b0;
      key_d  = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      down_q <= 1'b0;
      key_q  <= 8'h00;
    end else if (upd_en) begin
      idle_q <= idle_d;
      down_q <= down_d;
      key_q  <= key_d;
    end
  end

  assign idle_req = idle_q;
  assign down_req = down_q;
  assign key_ok   = (key_q == UNLOCK_KEY);
  assign rdata    = (addr == ADDR_KEY) ? key_q : {6'b0, down_q, idle_q};
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   idle_req,
  input  logic   down_req,
  input  logic   key_ok,
  input  logic   irq_wake,
  input  logic   wake_sync,
  output state_e state,
  output logic   resume,
  output logic   clr_idle,
  output logic   clr_all
);
  localparam int              CNT_W    = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  state_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    resume   = 1'b0;
    clr_idle = 1'b0;
    clr_all  = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (key_ok && down_req)      st_d = ST_DOWN;
        else if (key_ok && idle_req) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (irq_wake) begin
          st_d     = ST_RUN;
          clr_idle = 1'b1;
        end
      end
      ST_DOWN: begin
        if (wake_sync) begin
          st_d  = ST_WARM;
          cnt_d = '0;
        end
      end
      default: begin
        if (cnt_q == CNT_LAST) begin
          st_d    = ST_RUN;
          resume  = 1'b1;
          clr_all = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  assign cnt_en = (st_q == ST_WARM) || (st_d == ST_WARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state = st_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_wake,
  input  logic       wake_async,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic [1:0] mode,
  output logic       resume
);
  logic   rst_sn;
  logic   wake_sync;
  logic   idle_req, down_req, key_ok;
  logic   clr_idle, clr_all;
  logic   wr_ok;
  state_e state;

  lpm_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(arst_n), .d(1'b1), .q(rst_sn)
  );

  lpm_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
    .clk(clk), .rst_n(rst_sn), .d(wake_async), .q(wake_sync)
  );

  assign wr_ok = reg_wr && (state == ST_RUN);

  lpm_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_ok), .addr(reg_addr),
    .wdata(reg_wdata), .clr_idle(clr_idle), .clr_all(clr_all),
    .idle_req(idle_req), .down_req(down_req), .key_ok(key_ok),
    .rdata(reg_rdata)
  );

  lpm_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .idle_req(idle_req), .down_req(down_req),
    .key_ok(key_ok), .irq_wake(irq_wake), .wake_sync(wake_sync),
    .state(state), .resume(resume), .clr_idle(clr_idle), .clr_all(clr_all)
  );

  assign cpu_clk_en = (state == ST_RUN);
  assign per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
  assign osc_en     = (state != ST_DOWN) || wake_async;

  always_comb begin
    case (state)
      ST_RUN:  mode = MODE_RUN;
      ST_IDLE: mode = MODE_IDLE;
      default: mode = MODE_DOWN;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       resume,
  input logic       irq_wake,
  input logic       key_ok,
  input logic       idle_req,
  input logic       down_req
);
  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mode == 2'b01 |-> (!cpu_clk_en && per_clk_en && osc_en));

  // R5
  down_clk_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mode == 2'b10 |-> (!cpu_clk_en && !per_clk_en));

  // R4
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 2'b00 && key_ok && idle_req && !down_req) |=> mode == 2'b01);

  // R7
  down_prio_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 2'b00 && key_ok && down_req) |=> mode == 2'b10);

  // R6
  no_key_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 2'b00 && !key_ok) |=> mode == 2'b00);

  // R8
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == 2'b01 && irq_wake) |=> (mode == 2'b00 && !key_ok && !idle_req));

  // R10
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    resume |=> (!resume && mode == 2'b00 && !key_ok && !down_req));

  // R12
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mode != 2'b11);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .mode(mode), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .osc_en(osc_en), .resume(resume),
  .irq_wake(irq_wake), .key_ok(key_ok), .idle_req(idle_req),
  .down_req(down_req)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int SETTLE = 5;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_wake;
  logic       wake_async;
  logic       cpu_clk_en, per_clk_en, osc_en, resume;
  logic [1:0] mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic       m_idle, m_down;
  logic [7:0] m_key;

  always #10 clk = ~clk;

  lpm_ctrl #(.SETTLE_CYC(SETTLE)) u_lpm_ctrl (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_wake(irq_wake),
    .wake_async(wake_async), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .mode(mode), .resume(resume)
  );

  function automatic logic [1:0] exp_mode(logic idl, logic dn, logic [7:0] key);
    if (key != 8'h55) return 2'b00;
    if (dn)  return 2'b10;
    if (idl) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_irq();
    irq_wake = 1'b1;
    tick();
    irq_wake = 1'b0;
  endtask

  task automatic wake_down();
    logic [7:0] v;
    wake_async = 1'b1;
    #1;
    check(osc_en == 1'b1, "R10", "osc_en on wake", osc_en, 1);
    for (int i = 1; i <= SETTLE + 1; i++) begin
      tick();
      check(resume == 1'b0 && mode == 2'b10, "R10", "settling",
            {mode, resume}, 3'b100);
    end
    tick();
    check(resume == 1'b1 && mode == 2'b10, "R10", "resume pulse",
          {mode, resume}, 3'b101);
    tick();
    wake_async = 1'b0;
    check(resume == 1'b0 && mode == 2'b00 && cpu_clk_en, "R10", "back in run",
          {mode, resume}, 3'b000);
    rd(1'b0, v);
    check(v == 8'h00, "R10", "ctrl cleared", v, 0);
    rd(1'b1, v);
    check(v == 8'h00, "R10", "key cleared", v, 0);
    m_idle = 0; m_down = 0; m_key = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    arst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    irq_wake = 0; wake_async = 0;
    m_idle = 0; m_down = 0; m_key = 0;
    repeat (3) tick();
    arst_n = 1;
    repeat (4) tick();

    // R1 reset state
    check(mode == 2'b00 && !resume, "R1", "mode/resume", {mode, resume}, 0);
    check(cpu_clk_en && per_clk_en && osc_en, "R1", "enables",
          {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    rd(1'b0, v); check(v == 8'h00, "R1", "ctrl reset", v, 0);
    rd(1'b1, v); check(v == 8'h00, "R1", "key reset", v, 0);

    // R2 reserved bits, R6 no key
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check(v == 8'h03, "R2", "ctrl readback", v, 3);
    tick();
    check(mode == 2'b00, "R6", "both reqs no key", mode, 0);
    wr(1'b1, 8'h54);
    rd(1'b1, v); check(v == 8'h54, "R3", "key readback", v, 8'h54);
    tick();
    check(mode == 2'b00, "R6", "near-miss key", mode, 0);

    // R7 priority, R5 clocks
    wr(1'b1, 8'h55);
    tick();
    check(mode == 2'b10, "R7", "down beats idle", mode, 2);
    check(!cpu_clk_en && !per_clk_en && !osc_en, "R5", "enables in down",
          {cpu_clk_en, per_clk_en, osc_en}, 0);
    pulse_irq();
    tick();
    check(mode == 2'b10, "R9", "irq in down", mode, 2);
    wake_down();

    // R4 idle entry, R11 write in idle, R8 exit
    wr(1'b1, 8'h55);
    tick();
    check(mode == 2'b00, "R6", "key only", mode, 0);
    wr(1'b0, 8'h01);
    tick();
    check(mode == 2'b01, "R4", "idle entry", mode, 1);
    check(!cpu_clk_en && per_clk_en && osc_en, "R4", "enables in idle",
          {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
    wr(1'b0, 8'h02);
    tick();
    check(mode == 2'b01, "R11", "write in idle", mode, 1);
    pulse_irq();
    check(mode == 2'b00, "R8", "idle exit", mode, 0);
    rd(1'b0, v); check(v == 8'h00, "R11", "ctrl after idle write", v, 0);
    rd(1'b1, v); check(v == 8'h00, "R8", "key cleared", v, 0);

    // R9 irq in run
    wr(1'b1, 8'h55);
    pulse_irq();
    rd(1'b1, v); check(v == 8'h55, "R9", "key after irq in run", v, 8'h55);
    check(mode == 2'b00, "R9", "mode after irq in run", mode, 0);
    wr(1'b1, 8'h00);
    m_idle = 0; m_down = 0; m_key = 0;

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic       a;
      logic [7:0] d;
      logic [1:0] em;
      a = 1'($urandom_range(0, 1));
      if (a) d = ($urandom_range(0, 1) == 1) ? 8'h55 : 8'($urandom);
      else   d = 8'($urandom);
      wr(a, d);
      if (a) m_key = d;
      else begin m_idle = d[0]; m_down = d[1]; end
      rd(a, v);
      check(v == (a ? m_key : {6'b0, m_down, m_idle}), a ? "R3" : "R2",
            "random readback", v, a ? m_key : {6'b0, m_down, m_idle});
      tick();
      em = exp_mode(m_idle, m_down, m_key);
      check(mode == em, em == 2'b10 ? "R5" : (em == 2'b01 ? "R4" : "R6"),
            "random mode", mode, em);
      if (mode == 2'b01) begin
        pulse_irq();
        check(mode == 2'b00, "R8", "random idle exit", mode, 0);
        m_idle = 0; m_key = 0;
      end else if (mode == 2'b10) begin
        wake_down();
      end
    end
    finish_run();
  end
endmodule